// File: doc/BRIEF.md
# Two-Group Interleaved Thread Picker

This block is the per-core thread selection stage of an in-order, fine-grained multithreaded integer pipeline. Eight hardware thread contexts are arranged as two groups of four, and each group feeds its own integer execution unit. On every cycle the picker looks at which threads have an instruction ready, which are held by a long-latency stall, and what class of integer instruction each one presents. It then names at most one thread per group to issue, so up to two instructions leave the stage each cycle.

Within a group the choice rotates: the search starts at the thread just after the one last granted in that group. The picker also models the two shared arithmetic resources whose occupancy decides readiness. A multiply may overlap with multiplies from other threads, but the issuing thread is frozen until its own result returns. A divide holds the single divider for its whole latency, and no other divide may start until it finishes. Grants are combinational from the current inputs and the registered picker state, and the state advances on the clock edge.

Top module: `thread_pick_stage`

## Requirements
- R1: After a synchronous active-low reset, no thread is held by a multiply or a divide, and in each group the lowest-numbered thread (local index 0) has first priority.
- R2: Each group grants at most one thread per cycle; group g covers threads g*4 to g*4+3, and bit i of `grant[g]` selects thread g*4+i.
- R3: A thread is granted only when its `thr_ready` bit is 1 and its `thr_stall` bit is 0.
- R4: Within a group, the grant goes to the first eligible thread found when searching upward, with wraparound, from the local index after the last thread granted in that group.
- R5: When no thread in a group is eligible, that group's grant is all zero, and its rotation pointer keeps its value.
- R6: The class of thread t is `thr_class[2t+1:2t]`: 00 and 11 mean other, 01 means multiply, 10 means divide. A thread granted with class 01 is not granted in any of the next MUL_LAT cycles (default 5), and is eligible again in the cycle after that.
- R7: Multiplies from different threads are not blocked by one another: two threads may issue multiplies in consecutive cycles.
- R8: After any divide is granted, no thread is granted a divide during the next DIV_LAT cycles (default 32); instructions of other classes from any thread are unaffected.
- R9: At most one divide is granted per cycle; when both groups would grant a divide in the same cycle, group 0 takes the divider and group 1 treats its divide thread as not eligible, possibly granting another of its threads.
- R10: The rotation pointer of one group moves only on that group's own grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_ready | input | 8 | Per-thread flag: an instruction is waiting |
| thr_stall | input | 8 | Per-thread long-latency stall flag |
| thr_class | input | 16 | Two bits per thread giving the instruction class |
| grant | output | 2x4 | Per-group one-hot-or-zero grant vector |

## Verification
The assertions assume that the inputs are stable once they have been driven in a cycle and that the class field of a thread only matters while its ready bit is set; they take nothing for granted about how often divides or multiplies arrive, since the picker itself must absorb back-to-back demand. The stimulus drives all inputs once per cycle away from the rising edge, and mixes directed sequences (a lone multiply thread, divides competing across the groups, bubbles between grants) with a long stretch of random ready, stall and class patterns weighted so that both arithmetic units are frequently contended.

// File: rtl/thread_pick_pkg.sv
// Shared types for the thread picker.
// Assumes a two-bit class code per thread as described in the brief.
package thread_pick_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN     = 2'b00,
        OP_MUL       = 2'b01,
        OP_DIV       = 2'b10,
        OP_PLAIN_ALT = 2'b11
    } op_class_e;

endpackage

// File: rtl/rr_arbiter.sv
// Round-robin one-of-N picker with a registered "last granted" index.
// Assumes N >= 2. The search begins one above the last granted index and
// wraps; a cycle with no request leaves the index untouched.
module rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] pick;
    logic             found;

    // Search upward from last_q+1 with wraparound and grant the first request.
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        pick  = last_q;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                pick     = IDX_W'(idx);
            end
        end
    end

    // Remember the granted index; reset so that index 0 comes first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (found) begin
            last_q <= pick;
        end
    end

    AST_GRANT_WITHIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R3

    AST_BUBBLE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (gnt == '0)); // R5

    AST_POINTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> $stable(last_q)); // R5

endmodule

// File: rtl/mul_hold_tracker.sv
// Per-thread multiply hold counters.
// A thread that issues a multiply is held for LAT cycles while its result
// is in flight. Assumes LAT >= 1. Other threads' multiplies are independent.
module mul_hold_tracker #(
    parameter int NT  = 8,
    parameter int LAT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] issue,
    output logic [NT-1:0] blocked
);
    localparam int CW = $clog2(LAT + 1);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [CW-1:0] cnt_q;

        // Load the latency on issue, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (issue[t]) begin
                cnt_q <= CW'(LAT);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end

        assign blocked[t] = (cnt_q != '0);

        AST_MUL_REISSUE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            issue[t] |-> !blocked[t]); // R6
    end

endmodule

// File: rtl/div_busy_tracker.sv
// Occupancy model of the single shared divider.
// A start loads the latency; the unit is busy until the count drains.
// Assumes LAT >= 1 and that the caller never starts while busy.
module div_busy_tracker #(
    parameter int LAT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;

    // Count the remaining divider cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LAT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy = (cnt_q != '0);

    AST_DIV_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8

endmodule

// File: rtl/thread_pick_stage.sv
// Thread select stage for an in-order multithreaded core.
// Threads are split into NUM_GROUPS groups of THREADS_PER_GROUP; each group
// grants at most one eligible thread per cycle by round robin. Eligibility
// folds in the ready and stall flags, a per-thread multiply hold and the
// shared divider's occupancy. Lower-numbered groups win the divider when
// several groups would start a divide in the same cycle.
// Assumes inputs are settled before the rising edge.
module thread_pick_stage
    import thread_pick_pkg::*;
#(
    parameter int NUM_GROUPS        = 2,
    parameter int THREADS_PER_GROUP = 4,
    parameter int MUL_LAT           = 5,
    parameter int DIV_LAT           = 32
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic [NUM_GROUPS*THREADS_PER_GROUP-1:0]          thr_ready,
    input  logic [NUM_GROUPS*THREADS_PER_GROUP-1:0]          thr_stall,
    input  logic [2*NUM_GROUPS*THREADS_PER_GROUP-1:0]        thr_class,
    output logic [NUM_GROUPS-1:0][THREADS_PER_GROUP-1:0]     grant
);
    localparam int NT  = NUM_GROUPS * THREADS_PER_GROUP;
    localparam int TPG = THREADS_PER_GROUP;

    logic [NT-1:0] is_mul;
    logic [NT-1:0] is_div;
    logic [NT-1:0] mul_blocked;
    logic [NT-1:0] elig_base;
    logic [NT-1:0] grant_flat;
    logic [NT-1:0] mul_issue;
    logic [NT-1:0] div_issue;
    logic          div_busy;

    // Decode each thread's class field.
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            op_class_e c;
            c         = op_class_e'(thr_class[2*t +: 2]);
            is_mul[t] = (c == OP_MUL);
            is_div[t] = (c == OP_DIV);
        end
    end

    assign elig_base = thr_ready & ~thr_stall & ~mul_blocked;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [TPG-1:0] req;
        logic [TPG-1:0] gnt;
        logic           div_in;
        logic           div_here;

        if (g == 0) begin : g_first
            assign div_in = div_busy;
        end else begin : g_rest
            assign div_in = g_grp[g-1].div_in | g_grp[g-1].div_here;
        end

        // Mask divide threads when the divider is busy or already claimed.
        always_comb begin
            for (int i = 0; i < TPG; i++) begin
                req[i] = elig_base[g*TPG + i] & ~(is_div[g*TPG + i] & div_in);
            end
        end

        rr_arbiter #(
            .N(TPG)
        ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req),
            .gnt   (gnt)
        );

        assign div_here                = |(gnt & is_div[g*TPG +: TPG]);
        assign grant[g]                = gnt;
        assign grant_flat[g*TPG +: TPG] = gnt;

        AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[g])); // R2
    end

    assign mul_issue = grant_flat & is_mul;
    assign div_issue = grant_flat & is_div;

    mul_hold_tracker #(
        .NT  (NT),
        .LAT (MUL_LAT)
    ) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (mul_issue),
        .blocked (mul_blocked)
    );

    div_busy_tracker #(
        .LAT (DIV_LAT)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (|div_issue),
        .busy  (div_busy)
    );

    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_flat & ~(thr_ready & ~thr_stall)) == '0); // R3

    AST_SINGLE_DIV_START: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(div_issue) <= 1); // R9

    AST_MUL_THREAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_issue != '0) |=> ((grant_flat & $past(mul_issue)) == '0)); // R6

    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_issue != '0) |=> (div_issue == '0)); // R8

endmodule

// File: tb/test_thread_pick_stage.sv
// Bench for thread_pick_stage: behavioural reference model compared every cycle,
// plus directed expectations for each requirement.
module test_thread_pick_stage;
    localparam int NG      = 2;
    localparam int TPG     = 4;
    localparam int NT      = NG * TPG;
    localparam int MUL_LAT = 5;
    localparam int DIV_LAT = 32;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NT-1:0]           rdy;
    logic [NT-1:0]           stl;
    logic [2*NT-1:0]         cls;
    logic [NG-1:0][TPG-1:0]  gnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mulcnt[NT];
    int divcnt;
    int last[NG];
    logic [NG-1:0][TPG-1:0] expg;

    always #10 clk = ~clk;

    thread_pick_stage #(
        .NUM_GROUPS        (NG),
        .THREADS_PER_GROUP (TPG),
        .MUL_LAT           (MUL_LAT),
        .DIV_LAT           (DIV_LAT)
    ) i_thread_pick_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_ready (rdy),
        .thr_stall (stl),
        .thr_class (cls),
        .grant     (gnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) mulcnt[t] = 0;
        divcnt = 0;
        for (int g = 0; g < NG; g++) last[g] = TPG - 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rdy = '0; stl = '0; cls = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Expected grants from the model state and current inputs.
    task automatic model_expect();
        bit div_taken;
        div_taken = 1'b0;
        for (int g = 0; g < NG; g++) begin
            expg[g] = '0;
            for (int k = 1; k <= TPG; k++) begin
                int idx;
                int t;
                int c;
                idx = (last[g] + k) % TPG;
                t   = g * TPG + idx;
                c   = int'(cls[2*t +: 2]);
                if (expg[g] == '0 && rdy[t] && !stl[t] && mulcnt[t] == 0 &&
                    !(c == 2 && (divcnt > 0 || div_taken))) begin
                    expg[g][idx] = 1'b1;
                    if (c == 2) div_taken = 1'b1;
                end
            end
        end
    endtask

    // Advance the model as the clock edge will.
    task automatic model_advance();
        for (int t = 0; t < NT; t++) if (mulcnt[t] > 0) mulcnt[t]--;
        if (divcnt > 0) divcnt--;
        for (int g = 0; g < NG; g++) begin
            for (int i = 0; i < TPG; i++) begin
                if (expg[g][i]) begin
                    int t;
                    int c;
                    t = g * TPG + i;
                    c = int'(cls[2*t +: 2]);
                    last[g] = i;
                    if (c == 1) mulcnt[t] = MUL_LAT;
                    if (c == 2) divcnt = DIV_LAT;
                end
            end
        end
    endtask

    // Drive one cycle of inputs, compare against the model, then advance it.
    task automatic step(input logic [NT-1:0] r, input logic [NT-1:0] s,
                        input logic [2*NT-1:0] c, input string tag);
        @(negedge clk);
        rdy = r; stl = s; cls = c;
        #2;
        model_expect();
        for (int g = 0; g < NG; g++) begin
            check($sformatf("%s model grp%0d", tag, g), int'(gnt[g]), int'(expg[g]));
            check($sformatf("R2 onehot grp%0d", g), int'($countones(gnt[g]) <= 1), 1);
        end
        model_advance();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rdy = '0; stl = '0; cls = '0;
        model_reset();

        // R1: reset state; thread 0 of each group first, then rotation (R4).
        do_reset();
        #2;
        check("R1 idle after reset", int'(gnt), 0);
        step('1, '0, '0, "R1");
        check("R1 g0 first pick", int'(gnt[0]), 4'b0001);
        check("R1 g1 first pick", int'(gnt[1]), 4'b0001);
        step('1, '0, '0, "R4");
        check("R4 g0 rotates", int'(gnt[0]), 4'b0010);
        step('1, '0, '0, "R4");
        check("R4 g1 rotates", int'(gnt[1]), 4'b0100);

        // R3: stalled thread skipped.
        do_reset();
        step('1, 8'h01, '0, "R3");
        check("R3 stalled t0 skipped", int'(gnt[0]), 4'b0010);
        step(8'h0E, 8'h00, '0, "R3");
        check("R3 not-ready t0 skipped", int'(gnt[0]), 4'b0100);

        // R5 and R10: bubble keeps pointer; groups independent.
        do_reset();
        step(8'h04, '0, '0, "R5");
        check("R5 g1 bubble", int'(gnt[1]), 0);
        step(8'h10, '0, '0, "R5");
        check("R5 g0 bubble", int'(gnt[0]), 0);
        check("R10 g1 from own pointer", int'(gnt[1]), 4'b0001);
        step(8'h0F, '0, '0, "R5");
        check("R5 pointer kept over bubble", int'(gnt[0]), 4'b1000);

        // R6: multiply holds its own thread for MUL_LAT cycles.
        do_reset();
        step(8'h01, '0, 16'h0001, "R6");
        check("R6 mul issue", int'(gnt[0]), 4'b0001);
        for (int n = 0; n < MUL_LAT; n++) begin
            step(8'h01, '0, 16'h0001, "R6");
            check("R6 thread held", int'(gnt[0]), 0);
        end
        step(8'h01, '0, 16'h0001, "R6");
        check("R6 thread released", int'(gnt[0]), 4'b0001);

        // R7: multiplies from different threads back to back.
        do_reset();
        step(8'h03, '0, 16'h0005, "R7");
        check("R7 first mul", int'(gnt[0]), 4'b0001);
        step(8'h03, '0, 16'h0005, "R7");
        check("R7 second thread mul", int'(gnt[0]), 4'b0010);

        // R8: divider occupancy blocks other divides only.
        do_reset();
        step(8'h10, '0, 16'h0200, "R8");
        check("R8 div start", int'(gnt[1]), 4'b0001);
        for (int n = 0; n < DIV_LAT; n++) begin
            step(8'h21, '0, 16'h0800, "R8");
            check("R8 div held off", int'(gnt[1]), 0);
            check("R8 plain unaffected", int'(gnt[0]), 4'b0001);
        end
        step(8'h21, '0, 16'h0800, "R8");
        check("R8 div after drain", int'(gnt[1]), 4'b0010);

        // R9: same-cycle divide contention, group 0 wins.
        do_reset();
        step(8'h31, '0, 16'h0202, "R9");
        check("R9 g0 takes divider", int'(gnt[0]), 4'b0001);
        check("R9 g1 picks plain thread", int'(gnt[1]), 4'b0010);

        // Random traffic against the model.
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            logic [2*NT-1:0] c;
            for (int t = 0; t < NT; t++) begin
                int r;
                r = $urandom_range(0, 9);
                c[2*t +: 2] = (r < 3) ? 2'b01 : (r < 5) ? 2'b10 : (r == 9) ? 2'b11 : 2'b00;
            end
            step(NT'($urandom), NT'($urandom) & NT'($urandom), c, "R4 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule